// File: doc/BRIEF.md
# Accumulator Processor Datapath

This block is the 8-bit datapath of a small accumulator machine. It holds an accumulator fed by an adder/subtracter, an instruction register, a program counter and the multiplexer that picks the memory address. Every arithmetic result combines the current accumulator with the word on the memory data-in bus, and every word written to memory comes from the accumulator. An external controller drives the load, clear, count, select and write inputs one cycle at a time.

The instruction register has a second job. During a store it captures the operand word that follows the opcode, and that word then goes out on the address bus in place of the program counter. A built-in three-step sequencer can run the whole store on its own after a single `seq_go` pulse: it fetches the opcode, fetches the operand, and writes the accumulator to the operand address. The program counter then points at the next instruction.

Top module: `acc_datapath`

## Requirements
- R1: When `ld_acc` is 1, `sub_sel` is 0 and `clr_acc` is 0, the accumulator takes (accumulator + `mem_din`) mod 256 at the rising edge.
- R2: When `ld_acc` is 1, `sub_sel` is 1 and `clr_acc` is 0, the accumulator takes (accumulator − `mem_din`) mod 256.
- R3: With `ld_acc` at 0 the accumulator holds its value. `clr_acc` sets it to 0 and wins over `ld_acc`.
- R4: `acc_zero` is 1 exactly when the accumulator is 0, and `mem_dout` always carries the accumulator.
- R5: When `ld_ir` is 1, the instruction register loads `mem_din` at the rising edge; otherwise it holds.
- R6: The program counter gives priority to `clr_pc` (to 0), then to `pc_ld` (loads `mem_din`), then to `pc_inc` (adds 1, wrapping 255 to 0). It holds when none of these is asserted.
- R7: `mem_addr` is the program counter when `adr_sel` is 0 and the instruction register when it is 1. `mem_we` is 1 (write) or 0 (read) following `wr_req`.
- R8: A `seq_go` pulse while idle starts a three-cycle store and holds `seq_busy` at 1 for those cycles. The first cycle reads at the PC, loads the IR and increments the PC. The second reads at the PC and loads the IR. The third writes the accumulator to the IR address and increments the PC. All external control inputs except `rst` are ignored while busy.
- R9: A synchronous `rst` clears the accumulator, the instruction register, the program counter and the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of all state |
| clr_acc | input | 1 | Clear accumulator |
| ld_acc | input | 1 | Load ALU result into accumulator |
| sub_sel | input | 1 | 1 subtract, 0 add |
| ld_ir | input | 1 | Load instruction register from data-in |
| clr_pc | input | 1 | Clear program counter |
| pc_ld | input | 1 | Load program counter from data-in |
| pc_inc | input | 1 | Increment program counter |
| adr_sel | input | 1 | Address source: 0 PC, 1 IR |
| wr_req | input | 1 | Write strobe request |
| seq_go | input | 1 | Start the built-in store sequence |
| mem_din | input | 8 | Data read from memory |
| mem_addr | output | 8 | Memory address |
| mem_dout | output | 8 | Data written to memory (accumulator) |
| mem_we | output | 1 | 0 read, 1 write |
| acc_q | output | 8 | Accumulator value |
| acc_zero | output | 1 | Accumulator equals zero |
| ir_q | output | 8 | Instruction register value |
| pc_q | output | 8 | Program counter value |
| seq_busy | output | 1 | Store sequence in progress |

## Verification
The assertions assume that `mem_din` is a settled function of `mem_addr` within the cycle, as a combinational memory provides. They also assume that `rst` may arrive at any edge, which is why every property is disabled while it is high. The bench serves data from a combinational memory model and updates it from `mem_we` at each edge. It draws random control vectors in which `seq_go`, `rst` and the clears are rare, so that long arithmetic runs and complete store sequences both occur. It drives `seq_go` and other controls during busy cycles to show that they have no effect.

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_acc,
  input  logic         ld_acc,
  input  logic         sub_sel,
  input  logic         ld_ir,
  input  logic         clr_pc,
  input  logic         pc_ld,
  input  logic         pc_inc,
  input  logic         adr_sel,
  input  logic         wr_req,
  input  logic         seq_go,
  input  logic [W-1:0] mem_din,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_dout,
  output logic         mem_we,
  output logic [W-1:0] acc_q,
  output logic         acc_zero,
  output logic [W-1:0] ir_q,
  output logic [W-1:0] pc_q,
  output logic         seq_busy
);

  typedef enum logic [1:0] {SQ_IDLE, SQ_OPC, SQ_OPR, SQ_WR} sq_t;
  sq_t sq;

  logic e_clr_acc, e_ld_acc, e_ld_ir, e_clr_pc, e_pc_ld, e_pc_inc, e_sel, e_we;
  logic [W-1:0] alu;

  assign seq_busy = (sq != SQ_IDLE);

  always_comb begin
    if (seq_busy) begin
      e_clr_acc = 1'b0;
      e_ld_acc  = 1'b0;
      e_clr_pc  = 1'b0;
      e_pc_ld   = 1'b0;
      e_ld_ir   = (sq == SQ_OPC) || (sq == SQ_OPR);
      e_pc_inc  = (sq == SQ_OPC) || (sq == SQ_WR);
      e_sel     = (sq == SQ_WR);
      e_we      = (sq == SQ_WR);
    end else begin
      e_clr_acc = clr_acc;
      e_ld_acc  = ld_acc;
      e_clr_pc  = clr_pc;
      e_pc_ld   = pc_ld;
      e_ld_ir   = ld_ir;
      e_pc_inc  = pc_inc;
      e_sel     = adr_sel;
      e_we      = wr_req;
    end
  end

  assign alu      = sub_sel ? acc_q - mem_din : acc_q + mem_din;
  assign mem_addr = e_sel ? ir_q : pc_q;
  assign mem_we   = e_we;
  assign mem_dout = acc_q;
  assign acc_zero = (acc_q == '0);

  always_ff @(posedge clk) begin
    if (rst || e_clr_acc) acc_q <= '0;
    else if (e_ld_acc)    acc_q <= alu;
  end

  always_ff @(posedge clk) begin
    if (rst)          ir_q <= '0;
    else if (e_ld_ir) ir_q <= mem_din;
  end

  always_ff @(posedge clk) begin
    if (rst || e_clr_pc) pc_q <= '0;
    else if (e_pc_ld)    pc_q <= mem_din;
    else if (e_pc_inc)   pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sq <= SQ_IDLE;
    else begin
      case (sq)
        SQ_IDLE: if (seq_go) sq <= SQ_OPC;
        SQ_OPC:  sq <= SQ_OPR;
        SQ_OPR:  sq <= SQ_WR;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

endmodule

module acc_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_acc,
  input logic         ld_acc,
  input logic         sub_sel,
  input logic         clr_pc,
  input logic         pc_ld,
  input logic         pc_inc,
  input logic         adr_sel,
  input logic [W-1:0] mem_din,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_dout,
  input logic         mem_we,
  input logic [W-1:0] acc_q,
  input logic         acc_zero,
  input logic [W-1:0] ir_q,
  input logic [W-1:0] pc_q,
  input logic         seq_busy
);

  p_add_r1: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && ld_acc && !clr_acc && !sub_sel) |=> acc_q == $past(acc_q + mem_din));

  p_sub_r2: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && ld_acc && !clr_acc && sub_sel) |=> acc_q == $past(acc_q - mem_din));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_busy || (!ld_acc && !clr_acc)) |=> $stable(acc_q));

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    acc_zero == (mem_dout == '0));

  p_pc_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && pc_inc && !pc_ld && !clr_pc) |=> pc_q == $past(pc_q) + 1'b1);

  p_addr_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && !adr_sel) |-> mem_addr == pc_q);

  p_store_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && mem_we) |-> mem_addr == ir_q);

  p_busy_run_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_busy) |=> seq_busy);

endmodule

bind acc_datapath acc_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .clr_acc(clr_acc), .ld_acc(ld_acc), .sub_sel(sub_sel),
  .clr_pc(clr_pc), .pc_ld(pc_ld), .pc_inc(pc_inc), .adr_sel(adr_sel),
  .mem_din(mem_din), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_we(mem_we),
  .acc_q(acc_q), .acc_zero(acc_zero), .ir_q(ir_q), .pc_q(pc_q), .seq_busy(seq_busy)
);

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, clr_acc, ld_acc, sub_sel, ld_ir, clr_pc, pc_ld, pc_inc, adr_sel, wr_req, seq_go;
  logic [7:0] mem_din, mem_addr, mem_dout, acc_q, ir_q, pc_q;
  logic mem_we, acc_zero, seq_busy;
  logic [7:0] mem [256];

  int n_run = 0, n_fail = 0;
  logic [7:0] m_acc, m_ir, m_pc;
  int m_st;

  assign mem_din = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_dout;

  acc_datapath u0 (.clk(clk), .rst(rst), .clr_acc(clr_acc), .ld_acc(ld_acc), .sub_sel(sub_sel),
    .ld_ir(ld_ir), .clr_pc(clr_pc), .pc_ld(pc_ld), .pc_inc(pc_inc), .adr_sel(adr_sel),
    .wr_req(wr_req), .seq_go(seq_go), .mem_din(mem_din), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_we(mem_we), .acc_q(acc_q), .acc_zero(acc_zero),
    .ir_q(ir_q), .pc_q(pc_q), .seq_busy(seq_busy));

  function automatic logic [7:0] alu_f(logic [7:0] a, logic [7:0] b, logic s);
    return s ? 8'(a - b) : 8'(a + b);
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(logic i_rst, logic i_ca, logic i_la, logic i_sub, logic i_li,
                      logic i_cp, logic i_pl, logic i_pi, logic i_sel, logic i_wr, logic i_go);
    logic bz, eca, ela, eli, ecp, epl, epi, esel, ewe;
    logic [7:0] addr, din;
    string ta;
    @(negedge clk);
    bz = (m_st != 0);
    chk(bz ? "R8 acc" : "R1/R2/R3 acc", acc_q, m_acc);
    chk("R5 ir", ir_q, m_ir);
    chk("R6 pc", pc_q, m_pc);
    chk("R4 zero", acc_zero, m_acc == 0);
    chk("R4 dout", mem_dout, m_acc);
    chk("R8 busy", seq_busy, bz);
    rst = i_rst; clr_acc = i_ca; ld_acc = i_la; sub_sel = i_sub; ld_ir = i_li;
    clr_pc = i_cp; pc_ld = i_pl; pc_inc = i_pi; adr_sel = i_sel; wr_req = i_wr; seq_go = i_go;
    if (bz) begin
      eca = 0; ela = 0; ecp = 0; epl = 0;
      eli = (m_st == 1 || m_st == 2);
      epi = (m_st == 1 || m_st == 3);
      esel = (m_st == 3); ewe = (m_st == 3);
    end else begin
      eca = i_ca; ela = i_la; ecp = i_cp; epl = i_pl; eli = i_li; epi = i_pi; esel = i_sel; ewe = i_wr;
    end
    addr = esel ? m_ir : m_pc;
    din = mem[addr];
    #1;
    chk(bz ? "R8 addr" : "R7 addr", mem_addr, addr);
    chk(bz ? "R8 we" : "R7 we", mem_we, ewe);
    if (i_rst) begin
      m_acc = 0; m_ir = 0; m_pc = 0; m_st = 0;
    end else begin
      if (eca) m_acc = 0; else if (ela) m_acc = alu_f(m_acc, din, i_sub);
      if (eli) m_ir = din;
      if (ecp) m_pc = 0; else if (epl) m_pc = din; else if (epi) m_pc = 8'(m_pc + 1);
      if (m_st == 0) m_st = i_go ? 1 : 0; else m_st = (m_st == 3) ? 0 : m_st + 1;
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    rst = 1; {clr_acc, ld_acc, sub_sel, ld_ir, clr_pc, pc_ld, pc_inc, adr_sel, wr_req, seq_go} = '0;
    m_acc = 'x; m_ir = 'x; m_pc = 'x; m_st = 0;
    @(negedge clk);
    step(1,0,0,0,0,0,0,0,0,0,0);
    // R9 reset state then R1 add, R2 subtract below zero
    step(0,0,0,0,0,0,0,0,0,0,0);
    mem[0] = 8'd5;
    step(0,0,1,0,0,0,0,0,0,0,0);
    step(0,0,1,1,0,0,0,0,0,0,0);
    step(0,0,1,1,0,0,0,0,0,0,0);
    // R3 clear wins over load
    step(0,1,1,0,0,0,0,0,0,0,0);
    // R6 load then wrap 255->0, clear wins over load
    mem[0] = 8'd255;
    step(0,0,0,0,0,0,1,1,0,0,0);
    step(0,0,0,0,0,0,0,1,0,0,0);
    step(0,0,0,0,0,1,1,1,0,0,0);
    // R5 IR load, R7 address from IR with write
    step(0,0,0,0,1,0,0,0,0,0,0);
    step(0,0,1,0,0,0,0,0,1,1,0);
    // R8 store sequence with noise on inputs while busy
    step(0,0,0,0,0,0,0,0,0,0,1);
    step(0,1,1,1,0,1,1,0,1,0,1);
    step(0,1,1,0,0,1,1,0,0,1,1);
    step(0,1,1,1,0,1,1,0,0,0,1);
    step(0,0,0,0,0,0,0,0,0,0,0);
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[5:0] == 0, r[10:8] == 0, r[11], r[12], r[13], r[18:16] == 0, r[21:19] == 0,
           r[22], r[23], r[24], r[29:27] == 0);
    end
    step(0,0,0,0,0,0,0,0,0,0,0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule